// File: doc/BRIEF.md
# Data Cache Tag Entry Checker

This block inspects a single data-cache tag entry that has been read out of the tag array. The entry arrives as two words, a 32-bit upper tag word and a 64-bit lower tag word, together with the 13-bit cache index that was used to read it. The block pulls the 5-bit coherence state out of the upper word. It checks that code against the short list of legal states and maps it to a compact 3-bit state code. When the state is legal, it also checks the two parity bits that protect the physical tag.

Alongside the checks, the block rebuilds the physical address of the line, splits the index into bank and set numbers, and presents the least-to-most-recently-used way order from the upper word. All results are registered. They appear one cycle after the input strobe and hold until the next strobe.

Top module: `dtag_state_check`

## Requirements
- R1: The state is upper-word bits 29:25. Codes 0x00, 0x0F, 0x13, 0x19, 0x16 and 0x1C give state_code 0, 1, 2, 3, 4 and 5 respectively, and err_state stays low.
- R2: Any other 5-bit state gives state_code 7 and raises err_state. In that case err_addr stays low, whatever the parity bits hold.
- R3: For a legal state, err_addr is raised if lower-word bit 11 differs from the XOR of lower-word bits 39:26.
- R4: For a legal state, err_addr is raised if lower-word bit 10 differs from the XOR of lower-word bits 25:13. When both parity bits match, err_addr is low.
- R5: phys_addr[39:13] equals lower-word bits 39:13, and phys_addr[12:0] equals the index.
- R6: lru_order equals upper-word bits 21:14. Bits 1:0 hold the least recently used way, and each higher 2-bit pair holds the next more recent way, up to bits 7:6 for the most recently used way.
- R7: bank equals {index[12], index[5]}, and set_num equals index[11:6].
- R8: out_valid is high exactly in the cycle after in_valid. All other outputs change only after a strobe and otherwise keep their last values.
- R9: After reset, out_valid, err_state, err_addr, state_code, phys_addr, lru_order, bank and set_num are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Strobe: the tag words and index are valid |
| tag_hi | input | 32 | Upper tag word (state and LRU fields) |
| tag_lo | input | 64 | Lower tag word (physical tag and parity bits) |
| line_index | input | 13 | Cache index used for the read |
| out_valid | output | 1 | Results valid, one cycle after the strobe |
| err_state | output | 1 | Illegal coherence state |
| err_addr | output | 1 | Physical-tag parity mismatch on a legal state |
| state_code | output | 3 | Compact state code (0 to 5 legal, 7 illegal) |
| phys_addr | output | 40 | Line physical address |
| lru_order | output | 8 | Four 2-bit way numbers, least recently used way in the low pair |
| bank | output | 2 | Bank number from the index |
| set_num | output | 6 | Set number from the index |

## Verification
The hardest case to reach is an illegal state code that also carries wrong parity. In that case the parity result has to be masked, and a design that checks parity unconditionally would still look correct on every legal input. The stimulus reaches it by sweeping all 32 state codes. Each code is crossed with all four good/bad combinations of the two parity bits, on pseudo-random tag and index contents. Parity is deliberately set right or wrong for each half, so double faults and faults in a single half are both covered.

// File: rtl/dtag_pkg.sv
package dtag_pkg;
   localparam int STATE_W = 5;
   localparam int CODE_W  = 3;

   localparam logic [STATE_W-1:0] RAW_INVALID = 5'h00;
   localparam logic [STATE_W-1:0] RAW_SHARED  = 5'h0F;
   localparam logic [STATE_W-1:0] RAW_NCX_CLN = 5'h13;
   localparam logic [STATE_W-1:0] RAW_NCX_DRT = 5'h19;
   localparam logic [STATE_W-1:0] RAW_CX_CLN  = 5'h16;
   localparam logic [STATE_W-1:0] RAW_CX_DRT  = 5'h1C;

   typedef enum logic [CODE_W-1:0] {
      ST_INVALID = 3'd0,
      ST_SHARED  = 3'd1,
      ST_NCX_CLN = 3'd2,
      ST_NCX_DRT = 3'd3,
      ST_CX_CLN  = 3'd4,
      ST_CX_DRT  = 3'd5,
      ST_ILLEGAL = 3'd7
   } dstate_e;
endpackage

// File: rtl/dtag_state_decode.sv
module dtag_state_decode
   import dtag_pkg::*;
(
   input  logic [STATE_W-1:0] raw_state,
   output logic [CODE_W-1:0]  code,
   output logic               legal
);
   dstate_e code_e;

   always_comb begin
      unique case (raw_state)
         RAW_INVALID: code_e = ST_INVALID;
         RAW_SHARED:  code_e = ST_SHARED;
         RAW_NCX_CLN: code_e = ST_NCX_CLN;
         RAW_NCX_DRT: code_e = ST_NCX_DRT;
         RAW_CX_CLN:  code_e = ST_CX_CLN;
         RAW_CX_DRT:  code_e = ST_CX_DRT;
         default:     code_e = ST_ILLEGAL;
      endcase
   end

   assign code  = code_e;
   assign legal = (code_e != ST_ILLEGAL);
endmodule

// File: rtl/dtag_range_parity.sv
module dtag_range_parity #(
   parameter int WORD_W = 64,
   parameter int HI     = 39,
   parameter int LO     = 26,
   parameter int PBIT   = 11
) (
   input  logic [WORD_W-1:0] word,
   output logic              mismatch
);
   localparam int SPAN = HI - LO + 1;

   generate
      if (HI >= WORD_W || LO < 0 || HI < LO || PBIT >= WORD_W ||
          (PBIT >= LO && PBIT <= HI)) begin : g_bad_cfg
         $error("dtag_range_parity: bad range or parity bit position");
      end
   endgenerate

   logic [SPAN-1:0] slice;
   assign slice    = word[HI:LO];
   assign mismatch = (^slice) ^ word[PBIT];
endmodule

// File: rtl/dtag_addr_form.sv
module dtag_addr_form #(
   parameter int TAG_W  = 64,
   parameter int PA_W   = 40,
   parameter int IDX_W  = 13,
   parameter int BANK_HI_BIT = 12,
   parameter int BANK_LO_BIT = 5,
   parameter int SET_LO = 6,
   parameter int SET_W  = 6
) (
   input  logic [TAG_W-1:0] tag_lo,
   input  logic [IDX_W-1:0] index,
   output logic [PA_W-1:0]  pa,
   output logic [1:0]       bank,
   output logic [SET_W-1:0] set_num
);
   generate
      if (PA_W <= IDX_W || PA_W > TAG_W) begin : g_bad_pa
         $error("dtag_addr_form: address width must exceed index width and fit the tag");
      end
      if (SET_LO + SET_W > IDX_W || BANK_HI_BIT >= IDX_W) begin : g_bad_idx
         $error("dtag_addr_form: bank or set field outside index");
      end
   endgenerate

   assign pa      = {tag_lo[PA_W-1:IDX_W], index};
   assign bank    = {index[BANK_HI_BIT], index[BANK_LO_BIT]};
   assign set_num = index[SET_LO +: SET_W];
endmodule

// File: rtl/dtag_state_check.sv
module dtag_state_check
   import dtag_pkg::*;
#(
   parameter int HI_W      = 32,
   parameter int LO_W      = 64,
   parameter int IDX_W     = 13,
   parameter int PA_W      = 40,
   parameter int STATE_LSB = 25,
   parameter int LRU_LSB   = 14,
   parameter int WAYS      = 4,
   parameter int PT1_HI    = 39,
   parameter int PT1_LO    = 26,
   parameter int PT1_PAR   = 11,
   parameter int PT0_HI    = 25,
   parameter int PT0_LO    = 13,
   parameter int PT0_PAR   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [31:0]       tag_hi,
   input  logic [63:0]       tag_lo,
   input  logic [12:0]       line_index,
   output logic              out_valid,
   output logic              err_state,
   output logic              err_addr,
   output logic [2:0]        state_code,
   output logic [39:0]       phys_addr,
   output logic [7:0]        lru_order,
   output logic [1:0]        bank,
   output logic [5:0]        set_num
);
   localparam int WAY_W = $clog2(WAYS);
   localparam int LRU_W = WAYS * WAY_W;
   localparam int SET_W = 6;
   localparam int NPAR  = 2;

   generate
      if (HI_W != 32 || LO_W != 64 || IDX_W != 13 || PA_W != 40 || LRU_W != 8) begin : g_port_cfg
         $error("dtag_state_check: parameters disagree with port widths");
      end
      if (STATE_LSB + STATE_W > HI_W || LRU_LSB + LRU_W > HI_W) begin : g_field_cfg
         $error("dtag_state_check: field lies outside the upper tag word");
      end
   endgenerate

   logic [CODE_W-1:0] dec_code;
   logic              dec_legal;
   logic [NPAR-1:0]   par_bad;
   logic [PA_W-1:0]   pa_c;
   logic [1:0]        bank_c;
   logic [SET_W-1:0]  set_c;
   logic [LRU_W-1:0]  lru_c;

   dtag_state_decode u_decode (
      .raw_state (tag_hi[STATE_LSB +: STATE_W]),
      .code      (dec_code),
      .legal     (dec_legal)
   );

   dtag_range_parity #(.WORD_W(LO_W), .HI(PT1_HI), .LO(PT1_LO), .PBIT(PT1_PAR)) u_par_hi (
      .word     (tag_lo),
      .mismatch (par_bad[1])
   );

   dtag_range_parity #(.WORD_W(LO_W), .HI(PT0_HI), .LO(PT0_LO), .PBIT(PT0_PAR)) u_par_lo (
      .word     (tag_lo),
      .mismatch (par_bad[0])
   );

   dtag_addr_form #(.TAG_W(LO_W), .PA_W(PA_W), .IDX_W(IDX_W), .SET_W(SET_W)) u_addr (
      .tag_lo  (tag_lo),
      .index   (line_index),
      .pa      (pa_c),
      .bank    (bank_c),
      .set_num (set_c)
   );

   genvar w;
   generate
      for (w = 0; w < WAYS; w++) begin : g_lru
         assign lru_c[w*WAY_W +: WAY_W] = tag_hi[LRU_LSB + w*WAY_W +: WAY_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         err_state  <= 1'b0;
         err_addr   <= 1'b0;
         state_code <= '0;
         phys_addr  <= '0;
         lru_order  <= '0;
         bank       <= '0;
         set_num    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            err_state  <= !dec_legal;
            err_addr   <= dec_legal && (|par_bad);
            state_code <= dec_code;
            phys_addr  <= pa_c;
            lru_order  <= lru_c;
            bank       <= bank_c;
            set_num    <= set_c;
         end
      end
   end

   assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(phys_addr) && $stable(state_code) && $stable(err_addr));
   assert_state_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (err_state == (state_code == 3'd7)));
   assert_masked_parity_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(err_state && err_addr));
   assert_index_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> phys_addr[12:0] == $past(line_index));
   assert_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> bank == {$past(line_index[12]), $past(line_index[5])});
endmodule

// File: tb/dtag_state_check_bench.sv
module dtag_state_check_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] tag_hi = '0;
   logic [63:0] tag_lo = '0;
   logic [12:0] line_index = '0;
   logic        out_valid, err_state, err_addr;
   logic [2:0]  state_code;
   logic [39:0] phys_addr;
   logic [7:0]  lru_order;
   logic [1:0]  bank;
   logic [5:0]  set_num;

   int errors = 0;
   int checks = 0;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   always #10 clk = ~clk;

   dtag_state_check u_dtag_state_check (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .tag_hi(tag_hi),
      .tag_lo(tag_lo), .line_index(line_index), .out_valid(out_valid),
      .err_state(err_state), .err_addr(err_addr), .state_code(state_code),
      .phys_addr(phys_addr), .lru_order(lru_order), .bank(bank), .set_num(set_num)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] next_rand(input logic [63:0] s);
      logic [63:0] x;
      x = s;
      x = x ^ (x << 13);
      x = x ^ (x >> 7);
      x = x ^ (x << 17);
      return x;
   endfunction

   function automatic logic [2:0] expect_code(input logic [4:0] s);
      case (s)
         5'h00: return 3'd0;
         5'h0F: return 3'd1;
         5'h13: return 3'd2;
         5'h19: return 3'd3;
         5'h16: return 3'd4;
         5'h1C: return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   task automatic run_vector(input logic [4:0] st, input logic bad_hi, input logic bad_lo);
      logic [31:0] hi;
      logic [63:0] lo;
      logic [12:0] idx;
      logic [2:0]  ecode;
      logic        legal;
      seed = next_rand(seed);
      hi   = seed[63:32];
      lo   = next_rand(seed);
      seed = lo;
      idx  = seed[12:0] ^ seed[40:28];
      hi[29:25] = st;
      lo[11] = (^lo[39:26]) ^ bad_hi;
      lo[10] = (^lo[25:13]) ^ bad_lo;
      ecode = expect_code(st);
      legal = (ecode != 3'd7);
      @(negedge clk);
      tag_hi = hi; tag_lo = lo; line_index = idx; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 out_valid after strobe", out_valid, 1);
      check(legal ? "R1 state code" : "R2 illegal code", state_code, ecode);
      check(legal ? "R1 no state error" : "R2 state error", err_state, !legal);
      if (!legal)
         check("R2 parity masked", err_addr, 0);
      else if (bad_hi)
         check("R3 upper ptag parity", err_addr, 1);
      else if (bad_lo)
         check("R4 lower ptag parity", err_addr, 1);
      else
         check("R4 clean parity", err_addr, 0);
      check("R5 phys addr", phys_addr, {lo[39:13], idx});
      check("R6 lru order", lru_order, hi[21:14]);
      check("R7 bank", bank, {idx[12], idx[5]});
      check("R7 set", set_num, idx[11:6]);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      logic [39:0] held_pa;
      logic [2:0]  held_code;
      repeat (3) @(negedge clk);
      check("R9 reset out_valid", out_valid, 0);
      check("R9 reset err_state", err_state, 0);
      check("R9 reset err_addr", err_addr, 0);
      check("R9 reset state_code", state_code, 0);
      check("R9 reset phys_addr", phys_addr, 0);
      check("R9 reset lru/bank/set", {lru_order, bank, set_num}, 0);
      rst_n = 1'b1;
      for (int s = 0; s < 32; s++)
         for (int p = 0; p < 4; p++)
            run_vector(5'(s), p[1], p[0]);
      held_pa   = phys_addr;
      held_code = state_code;
      @(negedge clk);
      tag_hi = ~tag_hi; tag_lo = ~tag_lo; line_index = ~line_index;
      @(negedge clk);
      @(negedge clk);
      check("R8 no strobe out_valid", out_valid, 0);
      check("R8 hold phys_addr", phys_addr, held_pa);
      check("R8 hold state_code", state_code, held_code);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule